// File: doc/BRIEF.md
# Multicycle Instruction Controller with Trap States

This block is the state-register sequencer for a small multicycle processor that shares one memory between instruction and data accesses. Each cycle it reads the opcode held in the instruction register, the ALU overflow flag and an interrupt request. From its current state it drives the register-transfer strobes and the mux and ALU selects that the datapath needs for that step. It sequences register-register operations, OR with a zero-extended immediate, word load, word store, branch on equal and jump.

Three events leave the normal flow and go to dedicated trap states. An opcode that decodes to nothing known is the first. The second is an overflowing register-register ALU operation, whose write-back is then skipped. The third is an enabled interrupt request that is seen at the boundary between instructions. Each trap state does three things in one cycle. It records the faulting PC, which is the incremented PC minus 4 as the ALU computes it. It writes a cause code. It loads the program counter with a fixed handler address. Fetch then follows.

Top module: `mc_trap_ctrl`

## Requirements
- R1: While `rst` is high, `ctl_state` is 0 (fetch) and `pc_load`, `pc_load_if_eq`, `instr_latch`, `mem_read`, `mem_write`, `rf_write`, `fault_pc_wr`, `cause_wr` and `vec_load` are all 0. The first cycle after release is a fetch.
- R2: In fetch (state 0) the block asserts `mem_read`, `instr_latch` and `pc_load`. It drives `mem_addr_sel`=0 (PC), `src_a_sel`=0 (PC), `src_b_sel`=1 (constant 4), `alu_fn`=0 (add) and `pc_next_sel`=0 (ALU result). Decode (state 1) always follows.
- R3: In decode the block drives `src_a_sel`=0, `src_b_sel`=3 (sign-extended, shifted offset), `alu_fn`=0 and `imm_signed`=1. The next state depends on the opcode: 000000→4, 001101→6, 100011→8, 101011→11, 000100→2, 000010→3, and any other value→13.
- R4: State 4 drives `src_a_sel`=1 (register A), `src_b_sel`=0 (register B) and `alu_fn`=2 (function field). The next state is 5 if `alu_ovf` is low, or 14 if it is high. State 5 asserts `rf_write` with `dst_rd_sel`=1 and `wb_from_mem`=0.
- R5: State 6 drives `src_a_sel`=1, `src_b_sel`=2 (immediate), `imm_signed`=0 and `alu_fn`=3 (OR). State 7 follows and asserts `rf_write` with `dst_rd_sel`=0 and `wb_from_mem`=0.
- R6: State 8 drives `src_a_sel`=1, `src_b_sel`=2, `imm_signed`=1 and `alu_fn`=0. State 9 asserts `mem_read` with `mem_addr_sel`=1 (ALU output register). State 10 asserts `rf_write` with `dst_rd_sel`=0 and `wb_from_mem`=1.
- R7: State 11 drives the same address-add selects as state 8. State 12 follows and asserts `mem_write` with `mem_addr_sel`=1.
- R8: State 2 drives `src_a_sel`=1, `src_b_sel`=0 and `alu_fn`=1 (subtract). It asserts `pc_load_if_eq` with `pc_next_sel`=1 (branch target). State 3 asserts `pc_load` with `pc_next_sel`=2 (jump target).
- R9: `alu_ovf` has an effect only in state 4. After an overflow, `rf_write` stays 0 for the whole instruction. Overflow in any other state leaves the sequence unchanged.
- R10: States 13, 14 and 15 each assert `fault_pc_wr`, `cause_wr`, `pc_load` and `vec_load`. They drive `src_a_sel`=0, `src_b_sel`=1 and `alu_fn`=1 (PC minus 4), and `vec_addr` equals `VEC_ADDR` (default 0x8000_0080). `cause_val` is 10 in state 13, 12 in state 14 and 0 in state 15. Outside the trap states, `vec_addr` is 0.
- R11: Every trap state goes to fetch on the next cycle, whatever `irq` and `irq_en` are.
- R12: The block samples `irq` only in the last state of an instruction, which is one of states 2, 3, 5, 7, 10 or 12. If `irq` and `irq_en` are both high there, the next state is 15; otherwise it is fetch. All other states ignore `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_ovf | input | 1 | Signed overflow from the ALU |
| irq | input | 1 | External interrupt request |
| irq_en | input | 1 | Interrupt enable |
| ctl_state | output | 4 | Current state code |
| pc_load | output | 1 | Unconditional PC write |
| pc_load_if_eq | output | 1 | PC write qualified by the ALU zero flag |
| pc_next_sel | output | 2 | PC source: 0 ALU, 1 branch target, 2 jump target |
| instr_latch | output | 1 | Instruction register write |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| mem_read | output | 1 | Memory read |
| mem_write | output | 1 | Memory write |
| rf_write | output | 1 | Register file write |
| dst_rd_sel | output | 1 | Write register: 0 rt, 1 rd |
| wb_from_mem | output | 1 | Write data: 0 ALU output register, 1 memory data register |
| src_a_sel | output | 1 | ALU A: 0 PC, 1 register A |
| src_b_sel | output | 2 | ALU B: 0 register B, 1 constant 4, 2 immediate, 3 shifted immediate |
| alu_fn | output | 2 | ALU: 0 add, 1 subtract, 2 function field, 3 OR |
| imm_signed | output | 1 | Immediate extension: 1 sign, 0 zero |
| fault_pc_wr | output | 1 | Faulting-PC register write |
| cause_wr | output | 1 | Cause register write |
| cause_val | output | CAUSE_W | Cause code to record |
| vec_load | output | 1 | PC takes the handler address |
| vec_addr | output | ADDR_W | Handler address, valid with `vec_load` |

## Verification
All strobes decode from the state register alone, so a strobe is valid in the same cycle as the state it belongs to. Inputs such as `opcode`, `alu_ovf` and `irq` act only on the following state, one clock edge later. The bench drives each input on a falling edge while the block is in the state that consumes it. It then checks the resulting state and its strobes on the next falling edge, exactly one rising edge later. A trap state is therefore checked one cycle after the overflow or interrupt that caused it, and fetch one cycle after that.

// File: rtl/mct_pkg.sv
package mct_pkg;

    localparam int ST_W  = 4;
    localparam int OPC_W = 6;

    typedef enum logic [ST_W-1:0] {
        ST_FETCH    = 4'd0,
        ST_DECODE   = 4'd1,
        ST_BEQ      = 4'd2,
        ST_JMP      = 4'd3,
        ST_RT_EX    = 4'd4,
        ST_RT_WB    = 4'd5,
        ST_ORI_EX   = 4'd6,
        ST_ORI_WB   = 4'd7,
        ST_LW_EX    = 4'd8,
        ST_LW_MEM   = 4'd9,
        ST_LW_WB    = 4'd10,
        ST_SW_EX    = 4'd11,
        ST_SW_MEM   = 4'd12,
        ST_TRAP_RSV = 4'd13,
        ST_TRAP_OVF = 4'd14,
        ST_TRAP_IRQ = 4'd15
    } mct_state_e;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_LW    = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_SW    = 6'b101011;

    localparam int CAUSE_IRQ  = 0;
    localparam int CAUSE_RSVD = 10;
    localparam int CAUSE_OVF  = 12;

    typedef enum logic       {ASRC_PC = 1'b0, ASRC_REGA = 1'b1} asrc_e;
    typedef enum logic [1:0] {BSRC_REGB = 2'd0, BSRC_FOUR = 2'd1,
                              BSRC_IMM = 2'd2, BSRC_IMM_SH = 2'd3} bsrc_e;
    typedef enum logic [1:0] {AOP_ADD = 2'd0, AOP_SUB = 2'd1,
                              AOP_FUNCT = 2'd2, AOP_OR = 2'd3} aop_e;
    typedef enum logic [1:0] {PSRC_ALU = 2'd0, PSRC_TARGET = 2'd1,
                              PSRC_JUMP = 2'd2, PSRC_SPARE = 2'd3} psrc_e;
    typedef enum logic [1:0] {TRAP_NONE = 2'd0, TRAP_RSVD = 2'd1,
                              TRAP_OVF = 2'd2, TRAP_IRQ = 2'd3} trap_e;

    // Per-state control word carried from decoder to top.
    typedef struct packed {
        logic  pc_load;
        logic  pc_load_if_eq;
        psrc_e pc_next_sel;
        logic  instr_latch;
        logic  mem_addr_sel;
        logic  mem_read;
        logic  mem_write;
        logic  rf_write;
        logic  dst_rd_sel;
        logic  wb_from_mem;
        asrc_e src_a_sel;
        bsrc_e src_b_sel;
        aop_e  alu_fn;
        logic  imm_signed;
        trap_e trap;
    } mct_ctl_t;

    function automatic mct_state_e dispatch_op(input logic [OPC_W-1:0] op);
        mct_state_e s;
        case (op)
            OPC_RTYPE: s = ST_RT_EX;
            OPC_ORI:   s = ST_ORI_EX;
            OPC_LW:    s = ST_LW_EX;
            OPC_SW:    s = ST_SW_EX;
            OPC_BEQ:   s = ST_BEQ;
            OPC_JUMP:  s = ST_JMP;
            default:   s = ST_TRAP_RSV;
        endcase
        return s;
    endfunction

    // Last state of an instruction: the only place an interrupt is taken.
    function automatic logic ends_instr(input mct_state_e s);
        return (s == ST_BEQ)    || (s == ST_JMP)    || (s == ST_RT_WB) ||
               (s == ST_ORI_WB) || (s == ST_LW_WB)  || (s == ST_SW_MEM);
    endfunction

    function automatic int cause_of(input trap_e t);
        int c;
        case (t)
            TRAP_RSVD: c = CAUSE_RSVD;
            TRAP_OVF:  c = CAUSE_OVF;
            default:   c = CAUSE_IRQ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mct_state_reg.sv
module mct_state_reg
    import mct_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  mct_state_e nxt,
    output mct_state_e cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= ST_FETCH;
        else     cur <= nxt;
    end
endmodule

// File: rtl/mct_next_state.sv
module mct_next_state
    import mct_pkg::*;
(
    input  mct_state_e       cur,
    input  logic [OPC_W-1:0] opcode,
    input  logic             alu_ovf,
    input  logic             irq,
    input  logic             irq_en,
    output mct_state_e       nxt
);
    logic take_irq;

    assign take_irq = irq & irq_en;

    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: nxt = dispatch_op(opcode);
            ST_RT_EX:  nxt = alu_ovf ? ST_TRAP_OVF : ST_RT_WB;
            ST_ORI_EX: nxt = ST_ORI_WB;
            ST_LW_EX:  nxt = ST_LW_MEM;
            ST_LW_MEM: nxt = ST_LW_WB;
            ST_SW_EX:  nxt = ST_SW_MEM;
            default: begin
                // Instruction boundaries and trap states.
                if (ends_instr(cur) && take_irq) nxt = ST_TRAP_IRQ;
                else                             nxt = ST_FETCH;
            end
        endcase
    end
endmodule

// File: rtl/mct_strobe_decode.sv
module mct_strobe_decode
    import mct_pkg::*;
(
    input  mct_state_e cur,
    output mct_ctl_t   ctl
);
    always_comb begin
        ctl = '0;
        case (cur)
            ST_FETCH: begin
                ctl.mem_read    = 1'b1;
                ctl.instr_latch = 1'b1;
                ctl.pc_load     = 1'b1;
                ctl.src_a_sel   = ASRC_PC;
                ctl.src_b_sel   = BSRC_FOUR;
                ctl.alu_fn      = AOP_ADD;
                ctl.pc_next_sel = PSRC_ALU;
            end
            ST_DECODE: begin
                ctl.src_a_sel  = ASRC_PC;
                ctl.src_b_sel  = BSRC_IMM_SH;
                ctl.alu_fn     = AOP_ADD;
                ctl.imm_signed = 1'b1;
            end
            ST_BEQ: begin
                ctl.src_a_sel     = ASRC_REGA;
                ctl.src_b_sel     = BSRC_REGB;
                ctl.alu_fn        = AOP_SUB;
                ctl.pc_load_if_eq = 1'b1;
                ctl.pc_next_sel   = PSRC_TARGET;
            end
            ST_JMP: begin
                ctl.pc_load     = 1'b1;
                ctl.pc_next_sel = PSRC_JUMP;
            end
            ST_RT_EX: begin
                ctl.src_a_sel = ASRC_REGA;
                ctl.src_b_sel = BSRC_REGB;
                ctl.alu_fn    = AOP_FUNCT;
            end
            ST_RT_WB: begin
                ctl.rf_write   = 1'b1;
                ctl.dst_rd_sel = 1'b1;
            end
            ST_ORI_EX: begin
                ctl.src_a_sel  = ASRC_REGA;
                ctl.src_b_sel  = BSRC_IMM;
                ctl.imm_signed = 1'b0;
                ctl.alu_fn     = AOP_OR;
            end
            ST_ORI_WB: begin
                ctl.rf_write = 1'b1;
            end
            ST_LW_EX, ST_SW_EX: begin
                ctl.src_a_sel  = ASRC_REGA;
                ctl.src_b_sel  = BSRC_IMM;
                ctl.imm_signed = 1'b1;
                ctl.alu_fn     = AOP_ADD;
            end
            ST_LW_MEM: begin
                ctl.mem_read     = 1'b1;
                ctl.mem_addr_sel = 1'b1;
            end
            ST_LW_WB: begin
                ctl.rf_write    = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            ST_SW_MEM: begin
                ctl.mem_write    = 1'b1;
                ctl.mem_addr_sel = 1'b1;
            end
            ST_TRAP_RSV, ST_TRAP_OVF, ST_TRAP_IRQ: begin
                // ALU forms PC - 4 for the faulting-PC register.
                ctl.src_a_sel = ASRC_PC;
                ctl.src_b_sel = BSRC_FOUR;
                ctl.alu_fn    = AOP_SUB;
                ctl.pc_load   = 1'b1;
                if (cur == ST_TRAP_RSV)      ctl.trap = TRAP_RSVD;
                else if (cur == ST_TRAP_OVF) ctl.trap = TRAP_OVF;
                else                         ctl.trap = TRAP_IRQ;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/mc_trap_ctrl.sv
module mc_trap_ctrl
    import mct_pkg::*;
#(
    parameter int               ADDR_W   = 32,
    parameter int               CAUSE_W  = 5,
    parameter logic [ADDR_W-1:0] VEC_ADDR = 32'h8000_0080
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [5:0]         opcode,
    input  logic               alu_ovf,
    input  logic               irq,
    input  logic               irq_en,
    output logic [3:0]         ctl_state,
    output logic               pc_load,
    output logic               pc_load_if_eq,
    output logic [1:0]         pc_next_sel,
    output logic               instr_latch,
    output logic               mem_addr_sel,
    output logic               mem_read,
    output logic               mem_write,
    output logic               rf_write,
    output logic               dst_rd_sel,
    output logic               wb_from_mem,
    output logic               src_a_sel,
    output logic [1:0]         src_b_sel,
    output logic [1:0]         alu_fn,
    output logic               imm_signed,
    output logic               fault_pc_wr,
    output logic               cause_wr,
    output logic [CAUSE_W-1:0] cause_val,
    output logic               vec_load,
    output logic [ADDR_W-1:0]  vec_addr
);
    localparam logic [ADDR_W-1:0] VEC_NONE = '0;

    mct_state_e cur_st;
    mct_state_e nxt_st;
    mct_ctl_t   ctl;
    logic       live;
    logic       in_trap;

    mct_state_reg u_sreg (
        .clk (clk),
        .rst (rst),
        .nxt (nxt_st),
        .cur (cur_st)
    );

    mct_next_state u_next (
        .cur     (cur_st),
        .opcode  (opcode),
        .alu_ovf (alu_ovf),
        .irq     (irq),
        .irq_en  (irq_en),
        .nxt     (nxt_st)
    );

    mct_strobe_decode u_dec (
        .cur (cur_st),
        .ctl (ctl)
    );

    // Strobes are held quiet for as long as reset is applied.
    assign live    = ~rst;
    assign in_trap = (ctl.trap != TRAP_NONE) & live;

    assign ctl_state     = cur_st;
    assign pc_load       = ctl.pc_load & live;
    assign pc_load_if_eq = ctl.pc_load_if_eq & live;
    assign pc_next_sel   = ctl.pc_next_sel;
    assign instr_latch   = ctl.instr_latch & live;
    assign mem_addr_sel  = ctl.mem_addr_sel;
    assign mem_read      = ctl.mem_read & live;
    assign mem_write     = ctl.mem_write & live;
    assign rf_write      = ctl.rf_write & live;
    assign dst_rd_sel    = ctl.dst_rd_sel;
    assign wb_from_mem   = ctl.wb_from_mem;
    assign src_a_sel     = ctl.src_a_sel;
    assign src_b_sel     = ctl.src_b_sel;
    assign alu_fn        = ctl.alu_fn;
    assign imm_signed    = ctl.imm_signed;
    assign fault_pc_wr   = in_trap;
    assign cause_wr      = in_trap;
    assign cause_val     = CAUSE_W'(cause_of(ctl.trap));
    assign vec_load      = in_trap;
    assign vec_addr      = in_trap ? VEC_ADDR : VEC_NONE;

endmodule

// File: rtl/mct_chk.sv
module mct_chk #(
    parameter int CAUSE_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic [5:0]         opcode,
    input logic               alu_ovf,
    input logic               irq,
    input logic               irq_en,
    input logic [3:0]         ctl_state,
    input logic               pc_load,
    input logic               instr_latch,
    input logic               mem_read,
    input logic               mem_write,
    input logic               rf_write,
    input logic               fault_pc_wr,
    input logic               cause_wr,
    input logic [CAUSE_W-1:0] cause_val,
    input logic               vec_load
);
    logic at_boundary;
    logic known_op;
    logic want_irq;

    assign at_boundary = (ctl_state == 4'd2) || (ctl_state == 4'd3) ||
                         (ctl_state == 4'd5) || (ctl_state == 4'd7) ||
                         (ctl_state == 4'd10) || (ctl_state == 4'd12);
    assign known_op = (opcode == 6'b000000) || (opcode == 6'b000010) ||
                      (opcode == 6'b000100) || (opcode == 6'b001101) ||
                      (opcode == 6'b100011) || (opcode == 6'b101011);
    assign want_irq = at_boundary & irq & irq_en;

    // R1: reset keeps every write strobe low
    assert_rst_quiet_R1: assert property (@(posedge clk)
        rst |-> !(pc_load || instr_latch || mem_read || mem_write ||
                  rf_write || fault_pc_wr || cause_wr || vec_load));

    // R2: fetch is always followed by decode
    assert_fetch_decode_R2: assert property (@(posedge clk) disable iff (rst)
        (ctl_state == 4'd0) |=> (ctl_state == 4'd1));

    // R3: an unknown opcode in decode records cause 10
    assert_rsvd_trap_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl_state == 4'd1 && !known_op) |=>
        (ctl_state == 4'd13 && cause_wr && cause_val == CAUSE_W'(10)));

    // R4 and R9: overflow diverts to the trap with no register write
    assert_no_overflow_wb_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl_state == 4'd4 && alu_ovf) |=> (ctl_state == 4'd14 && !rf_write));

    // R9: the overflow trap is entered only from the R-type execute state
    assert_ovf_source_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl_state == 4'd14) |-> ($past(ctl_state) == 4'd4));

    // R10 and R11: a trap cycle is followed by a fetch
    assert_trap_then_fetch_R11: assert property (@(posedge clk) disable iff (rst)
        fault_pc_wr |=> (instr_latch && !fault_pc_wr && ctl_state == 4'd0));

    // R12: the interrupt trap only follows an enabled request at a boundary
    assert_irq_boundary_R12: assert property (@(posedge clk) disable iff (rst)
        (ctl_state == 4'd15) |-> $past(want_irq));

    // R12: an enabled request at a boundary is always taken
    assert_irq_taken_R12: assert property (@(posedge clk) disable iff (rst)
        want_irq |=> (ctl_state == 4'd15 && cause_val == CAUSE_W'(0)));

endmodule

bind mc_trap_ctrl mct_chk #(.CAUSE_W(CAUSE_W)) u_mct_chk (
    .clk         (clk),
    .rst         (rst),
    .opcode      (opcode),
    .alu_ovf     (alu_ovf),
    .irq         (irq),
    .irq_en      (irq_en),
    .ctl_state   (ctl_state),
    .pc_load     (pc_load),
    .instr_latch (instr_latch),
    .mem_read    (mem_read),
    .mem_write   (mem_write),
    .rf_write    (rf_write),
    .fault_pc_wr (fault_pc_wr),
    .cause_wr    (cause_wr),
    .cause_val   (cause_val),
    .vec_load    (vec_load)
);

// File: tb/test_mc_trap_ctrl.sv
`timescale 1ns/1ps
module test_mc_trap_ctrl;

    localparam int VEC = 32'h8000_0080;

    logic        clk = 1'b0;
    logic        rst;
    logic [5:0]  opcode;
    logic        alu_ovf, irq, irq_en;
    logic [3:0]  ctl_state;
    logic        pc_load, pc_load_if_eq, instr_latch, mem_addr_sel;
    logic        mem_read, mem_write, rf_write, dst_rd_sel, wb_from_mem;
    logic        src_a_sel, imm_signed, fault_pc_wr, cause_wr, vec_load;
    logic [1:0]  pc_next_sel, src_b_sel, alu_fn;
    logic [4:0]  cause_val;
    logic [31:0] vec_addr;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    mc_trap_ctrl i_mc_trap_ctrl (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf),
        .irq(irq), .irq_en(irq_en), .ctl_state(ctl_state),
        .pc_load(pc_load), .pc_load_if_eq(pc_load_if_eq),
        .pc_next_sel(pc_next_sel), .instr_latch(instr_latch),
        .mem_addr_sel(mem_addr_sel), .mem_read(mem_read),
        .mem_write(mem_write), .rf_write(rf_write), .dst_rd_sel(dst_rd_sel),
        .wb_from_mem(wb_from_mem), .src_a_sel(src_a_sel),
        .src_b_sel(src_b_sel), .alu_fn(alu_fn), .imm_signed(imm_signed),
        .fault_pc_wr(fault_pc_wr), .cause_wr(cause_wr),
        .cause_val(cause_val), .vec_load(vec_load), .vec_addr(vec_addr)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk_trap(input string req, input int st, input int cause);
        chk(req, "state", ctl_state, st);
        chk("R10", "fault_pc_wr", fault_pc_wr, 1);
        chk("R10", "cause_wr", cause_wr, 1);
        chk("R10", "cause_val", cause_val, cause);
        chk("R10", "pc_load", pc_load, 1);
        chk("R10", "vec_load", vec_load, 1);
        chk("R10", "vec_addr", vec_addr, VEC);
        chk("R10", "src_a_sel", src_a_sel, 0);
        chk("R10", "src_b_sel", src_b_sel, 1);
        chk("R10", "alu_fn", alu_fn, 1);
        chk("R9", "rf_write in trap", rf_write, 0);
    endtask

    task automatic to_decode(input logic [5:0] op);
        chk("R2", "fetch state", ctl_state, 0);
        opcode = op;
        step();
        chk("R3", "decode state", ctl_state, 1);
        chk("R3", "decode src_b_sel", src_b_sel, 3);
        chk("R3", "decode imm_signed", imm_signed, 1);
        step();
    endtask

    task automatic t_rtype(input bit ovf);
        to_decode(6'b000000);
        chk("R4", "exec state", ctl_state, 4);
        chk("R4", "alu_fn", alu_fn, 2);
        chk("R4", "src_a_sel", src_a_sel, 1);
        alu_ovf = ovf;
        step();
        alu_ovf = 1'b0;
        if (ovf) begin
            chk_trap("R9", 14, 12);
        end else begin
            chk("R4", "wb state", ctl_state, 5);
            chk("R4", "rf_write", rf_write, 1);
            chk("R4", "dst_rd_sel", dst_rd_sel, 1);
            chk("R10", "vec_addr idle", vec_addr, 0);
        end
        step();
        chk("R11", "back to fetch", ctl_state, 0);
    endtask

    task automatic t_ori(input bit irq_mid, input bit irq_end, input bit en);
        to_decode(6'b001101);
        chk("R5", "exec state", ctl_state, 6);
        chk("R5", "alu_fn or", alu_fn, 3);
        chk("R5", "imm_signed", imm_signed, 0);
        chk("R5", "src_b_sel", src_b_sel, 2);
        irq = irq_mid; irq_en = en;
        step();
        chk("R12", "wb state", ctl_state, 7);
        chk("R5", "rf_write", rf_write, 1);
        chk("R5", "dst_rd_sel", dst_rd_sel, 0);
        irq = irq_end;
        step();
        irq = 1'b0;
        if (irq_end && en) begin
            chk_trap("R12", 15, 0);
            step();
            chk("R11", "fetch after irq trap", ctl_state, 0);
        end else begin
            chk("R12", "no trap", ctl_state, 0);
        end
        irq_en = 1'b0;
    endtask

    task automatic t_lw();
        alu_ovf = 1'b1;
        to_decode(6'b100011);
        chk("R6", "addr state", ctl_state, 8);
        chk("R6", "alu_fn add", alu_fn, 0);
        chk("R6", "imm_signed", imm_signed, 1);
        step();
        chk("R9", "ovf ignored", ctl_state, 9);
        chk("R6", "mem_read", mem_read, 1);
        chk("R6", "mem_addr_sel", mem_addr_sel, 1);
        step();
        chk("R6", "wb state", ctl_state, 10);
        chk("R6", "wb_from_mem", wb_from_mem, 1);
        chk("R6", "rf_write", rf_write, 1);
        alu_ovf = 1'b0;
        step();
        chk("R6", "end", ctl_state, 0);
    endtask

    task automatic t_sw();
        to_decode(6'b101011);
        chk("R7", "addr state", ctl_state, 11);
        chk("R7", "src_b_sel", src_b_sel, 2);
        step();
        chk("R7", "mem state", ctl_state, 12);
        chk("R7", "mem_write", mem_write, 1);
        chk("R7", "mem_addr_sel", mem_addr_sel, 1);
        chk("R7", "rf_write", rf_write, 0);
        step();
        chk("R7", "end", ctl_state, 0);
    endtask

    task automatic t_branches();
        to_decode(6'b000100);
        chk("R8", "beq state", ctl_state, 2);
        chk("R8", "pc_load_if_eq", pc_load_if_eq, 1);
        chk("R8", "pc_next_sel", pc_next_sel, 1);
        chk("R8", "alu_fn sub", alu_fn, 1);
        step();
        to_decode(6'b000010);
        chk("R8", "jump state", ctl_state, 3);
        chk("R8", "pc_load", pc_load, 1);
        chk("R8", "pc_next_sel", pc_next_sel, 2);
        step();
        chk("R8", "end", ctl_state, 0);
    endtask

    task automatic t_undef(input logic [5:0] op);
        chk("R2", "fetch state", ctl_state, 0);
        opcode = op;
        step();
        irq = 1'b1; irq_en = 1'b1;   // decode and trap must ignore it
        step();
        chk_trap("R3", 13, 10);
        step();
        chk("R11", "fetch despite irq", ctl_state, 0);
        irq = 1'b0; irq_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1; opcode = '0; alu_ovf = 1'b0; irq = 1'b0; irq_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "reset state", ctl_state, 0);
        chk("R1", "pc_load", pc_load, 0);
        chk("R1", "instr_latch", instr_latch, 0);
        chk("R1", "mem_read", mem_read, 0);
        chk("R1", "vec_load", vec_load, 0);
        rst = 1'b0;
        #1;
        chk("R2", "fetch mem_read", mem_read, 1);
        chk("R2", "fetch instr_latch", instr_latch, 1);
        chk("R2", "fetch pc_load", pc_load, 1);
        chk("R2", "fetch src_b_sel", src_b_sel, 1);
        chk("R2", "fetch mem_addr_sel", mem_addr_sel, 0);
        t_rtype(1'b0);
        t_rtype(1'b1);
        t_ori(1'b0, 1'b0, 1'b0);
        t_ori(1'b1, 1'b0, 1'b1);
        t_ori(1'b0, 1'b1, 1'b0);
        t_ori(1'b0, 1'b1, 1'b1);
        t_lw();
        t_sw();
        t_branches();
        t_undef(6'b111111);
        t_undef(6'b000001);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule